// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

The block keeps wall-clock time in packed BCD. It counts tenths of a second, seconds, minutes and hours on a 12-hour dial with an AM/PM flag. A mains-rate tick input passes through a prescaler that divides by 5 for 50 Hz mains or by 6 for 60 Hz mains. Each prescaler wrap advances the tenths. A second register set, the alarm, has the same layout. After every advance the time is compared with the alarm, and a one-cycle alarm event is raised when all four fields match.

Software reaches the clock through four byte addresses: 0 for tenths, 1 for seconds, 2 for minutes and 3 for hours. The alarm-select input steers writes to the alarm set instead of the time set. Reading the hours takes a coherent snapshot of all four fields, and later reads return that snapshot until the tenths are read. The clock keeps counting underneath, so no time is lost. Writing the hours stops the clock, and writing the tenths starts it again, so a full time can be loaded without a carry slipping in between.

Top module: `bcd_tod_clock`

## Requirements
- R1: After reset, all four time fields read 0x00, the prescaler count is 0 and `alarm_o` is low, even though the time then equals the alarm.
- R2: While running, the first tick after reset advances the tenths. After that, the tenths advance once every 5 ticks when `sel_50hz_i` is 1 and once every 6 ticks when it is 0.
- R3: Tenths count 0 to 9, and 9 wraps to 0 with a carry into the seconds. Seconds and minutes are two BCD digits (low digit in bits 3:0, high digit in bits 6:4) that count 00 to 59, and 59 wraps to 00 with a carry into the next field.
- R4: The hours field holds the PM flag in bit 7 and two BCD digits in bits 4:0 (tens digit in bit 4). The hours count 00 to 11, and 09 goes to 10. When the hours pass 11 they become 00 and bit 7 inverts.
- R5: Written bytes are masked per field: tenths keep bits 3:0, seconds and minutes keep bits 6:0, and hours keep bits 7 and 4:0. This applies to the time set and the alarm set alike.
- R6: With `alarm_sel_i` = 1, a write updates only the alarm field at `addr_i`, and the time fields are unchanged.
- R7: `alarm_o` is high for exactly the one cycle after the advance that makes all four time fields equal to the alarm fields. Writes that make the fields equal do not raise it.
- R8: A read of address 3 freezes the values seen by reads at that moment, while counting continues. Reads then return the frozen values until a read of address 0, which returns the frozen tenths and releases the freeze.
- R9: A time write to address 3 stops the clock, and ticks are then ignored. A time write to address 0 restarts the clock from the same prescaler position.
- R10: Alarm writes, including to address 3, do not stop the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle mains tick pulse |
| sel_50hz_i | input | 1 | 1: divide ticks by 5; 0: divide by 6 |
| alarm_sel_i | input | 1 | 1: writes go to the alarm fields |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (drives freeze/release) |
| addr_i | input | 2 | Field address: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| alarm_o | output | 1 | One-cycle alarm event |

## Verification
The bench goes after the carry chain at full depth:
- 11:59:59.9 PM must roll to 00:00:00.0 AM. A design that compared the hours against 12, or left the flag alone, would show 12 or keep PM.
- 09 hours must step to 10. A binary adder would show 0x0A.

It loads a time of x:x:59.9, freezes it, and ticks. A design that froze the counter itself would lose the minute carry. A design that did not snapshot would return the rolled seconds before the tenths read.

It also checks the following:
- the alarm fires one cycle after the matching advance and only for one cycle, but not on an equalising write or straight out of reset;
- an alarm-side hours write leaves the clock running;
- the prescaler uses the right period for each mains rate.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef struct packed {
    logic [7:0] hr;   // [7] PM, [4:0] BCD
    logic [6:0] mn;
    logic [6:0] sc;
    logic [3:0] ts;
  } tod_t;

  typedef enum logic [1:0] {
    FLD_TS = 2'd0,
    FLD_SC = 2'd1,
    FLD_MN = 2'd2,
    FLD_HR = 2'd3
  } tod_fld_e;

  function automatic logic [7:0] tod_field(tod_t t, logic [1:0] a);
    case (a)
      FLD_TS:  tod_field = {4'b0, t.ts};
      FLD_SC:  tod_field = {1'b0, t.sc};
      FLD_MN:  tod_field = {1'b0, t.mn};
      default: tod_field = t.hr;
    endcase
  endfunction

  function automatic tod_t tod_store(tod_t t, logic [1:0] a, logic [7:0] d);
    tod_t r;
    r = t;
    case (a)
      FLD_TS:  r.ts = d[3:0];
      FLD_SC:  r.sc = d[6:0];
      FLD_MN:  r.mn = d[6:0];
      default: r.hr = {d[7], 2'b00, d[4:0]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tod_prescale.sv
module tod_prescale #(
  parameter int DIV_A = 5,
  parameter int DIV_B = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic sel_a_i,
  output logic step_o
);
  localparam int MAXD = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int W    = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] reload;

  assign reload = sel_a_i ? W'(DIV_A - 1) : W'(DIV_B - 1);
  assign step_o = tick_i && run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (tick_i && run_i) cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
  end

  a_r2_reload_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && sel_a_i) |=> cnt_q == W'(DIV_A - 1));
  a_r2_reload_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !sel_a_i) |=> cnt_q == W'(DIV_B - 1));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/tod_bcd_inc.sv
module tod_bcd_inc #(
  parameter int HI_MAX = 5
) (
  input  logic [6:0] val_i,
  output logic [6:0] val_o,
  output logic       carry_o
);
  logic [3:0] lo;
  logic [3:0] hi;

  always_comb begin
    lo = val_i[3:0] + 4'd1;
    hi = {1'b0, val_i[6:4]};
    if (lo > 4'd9) begin
      lo = 4'd0;
      hi = hi + 4'd1;
    end
    carry_o = (hi > 4'(HI_MAX));
    val_o   = carry_o ? 7'd0 : {hi[2:0], lo};
  end
endmodule

// File: rtl/tod_core.sv
module tod_core
  import tod_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       we_i,
  input  logic       alarm_sel_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output tod_t       time_o,
  output logic       run_o,
  output logic       alarm_o
);
  tod_t time_q, alarm_q, time_inc;
  logic halt_q;
  logic time_wr, alarm_wr;
  logic [1:0][6:0] bcd_cur, bcd_nxt;
  logic [1:0]      bcd_cy;
  logic [7:0] hr_nxt;
  logic [3:0] h_lo;
  logic [1:0] h_hi;
  logic [5:0] h_sum;

  assign time_wr  = we_i && !alarm_sel_i;
  assign alarm_wr = we_i && alarm_sel_i;
  assign run_o    = !halt_q && !time_wr;
  assign time_o   = time_q;

  assign bcd_cur[0] = time_q.sc;
  assign bcd_cur[1] = time_q.mn;

  for (genvar g = 0; g < 2; g++) begin : g_bcd
    tod_bcd_inc #(.HI_MAX(5)) u_inc (
      .val_i  (bcd_cur[g]),
      .val_o  (bcd_nxt[g]),
      .carry_o(bcd_cy[g])
    );
  end

  // 12-hour BCD step, PM flips on the 11 -> 00 wrap
  always_comb begin
    h_lo = time_q.hr[3:0] + 4'd1;
    h_hi = {1'b0, time_q.hr[4]};
    if (h_lo > 4'd9) begin
      h_lo = 4'd0;
      h_hi = h_hi + 2'd1;
    end
    h_sum = {h_hi, h_lo};
    if (h_sum > 6'h11) hr_nxt = {~time_q.hr[7], 7'd0};
    else               hr_nxt = {time_q.hr[7], 2'b00, h_sum[4:0]};
  end

  always_comb begin
    time_inc = time_q;
    if (time_q.ts >= 4'd9) begin
      time_inc.ts = 4'd0;
      time_inc.sc = bcd_nxt[0];
      if (bcd_cy[0]) begin
        time_inc.mn = bcd_nxt[1];
        if (bcd_cy[1]) time_inc.hr = hr_nxt;
      end
    end else begin
      time_inc.ts = time_q.ts + 4'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      alarm_q <= '0;
      halt_q  <= 1'b0;
      alarm_o <= 1'b0;
    end else begin
      if (time_wr) begin
        time_q <= tod_store(time_q, addr_i, wdata_i);
        if (addr_i == FLD_HR) halt_q <= 1'b1;
        if (addr_i == FLD_TS) halt_q <= 1'b0;
      end else if (step_i) begin
        time_q <= time_inc;
      end
      if (alarm_wr) alarm_q <= tod_store(alarm_q, addr_i, wdata_i);
      alarm_o <= step_i && !time_wr && (time_inc == alarm_q);
    end
  end

  a_r9_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !we_i) |=> time_q == $past(time_q));
  a_r4_pm_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !time_wr && time_q.ts == 4'd9 && time_q.sc == 7'h59 &&
     time_q.mn == 7'h59 && time_q.hr[4:0] == 5'h11)
    |=> (time_q.hr[4:0] == 5'h00) && (time_q.hr[7] != $past(time_q.hr[7])));
  a_r3_tenths_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !time_wr && time_q.ts == 4'd9) |=> time_q.ts == 4'd0);
  a_r6_alarm_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_wr && !step_i) |=> time_q == $past(time_q));
endmodule

// File: rtl/bcd_tod_clock.sv
module bcd_tod_clock
  import tod_pkg::*;
#(
  parameter int DIV_50 = 5,
  parameter int DIV_60 = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sel_50hz_i,
  input  logic       alarm_sel_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       alarm_o
);
  tod_t live, snap_q;
  logic frozen_q;
  logic run, step;

  tod_prescale #(.DIV_A(DIV_50), .DIV_B(DIV_60)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run),
    .sel_a_i(sel_50hz_i),
    .step_o (step)
  );

  tod_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .we_i       (we_i),
    .alarm_sel_i(alarm_sel_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .time_o     (live),
    .run_o      (run),
    .alarm_o    (alarm_o)
  );

  assign rdata_o = tod_field(frozen_q ? snap_q : live, addr_i);

  // Read-side snapshot; counting continues underneath
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      snap_q   <= '0;
    end else if (re_i) begin
      if (addr_i == FLD_HR && !frozen_q) begin
        frozen_q <= 1'b1;
        snap_q   <= live;
      end else if (addr_i == FLD_TS) begin
        frozen_q <= 1'b0;
      end
    end
  end

  a_r8_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_q |=> $stable(snap_q));
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == FLD_TS) |=> !frozen_q);
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |=> !alarm_o);
  a_r7_needs_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !alarm_o);
endmodule

// File: tb/bcd_tod_clock_tb.sv
module bcd_tod_clock_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       sel_50hz_i = 1'b1;
  logic       alarm_sel_i = 1'b0;
  logic       we_i = 1'b0;
  logic       re_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       alarm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bcd_tod_clock u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sel_50hz_i(sel_50hz_i),
    .alarm_sel_i(alarm_sel_i), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .alarm_o(alarm_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; tick_i = 0; we_i = 0; re_i = 0; alarm_sel_i = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    re_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic tick(output logic al);
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    al = alarm_o;
  endtask

  task automatic ticks(int n);
    logic al;
    for (int i = 0; i < n; i++) tick(al);
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s, logic [7:0] t);
    wr(2'd3, h); wr(2'd2, m); wr(2'd1, s); wr(2'd0, t);
  endtask

  task automatic check_time(string req, logic [7:0] h, logic [7:0] m, logic [7:0] s, logic [7:0] t);
    logic [7:0] v;
    rd(2'd3, v); chk({req, " hours"}, v, h);
    rd(2'd2, v); chk({req, " minutes"}, v, m);
    rd(2'd1, v); chk({req, " seconds"}, v, s);
    rd(2'd0, v); chk({req, " tenths"}, v, t);
  endtask

  task automatic test_reset();
    do_reset();
    chk("R1 alarm idle", {7'd0, alarm_o}, 8'd0);
    check_time("R1", 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R1 alarm still idle", {7'd0, alarm_o}, 8'd0);
  endtask

  task automatic test_prescale(logic s50);
    logic [7:0] v;
    int per;
    per = s50 ? 5 : 6;
    do_reset();
    sel_50hz_i = s50;
    ticks(1);
    rd(2'd0, v); chk("R2 first tick", v, 8'h01);
    ticks(per - 1);
    rd(2'd0, v); chk("R2 before period", v, 8'h01);
    ticks(1);
    rd(2'd0, v); chk("R2 full period", v, 8'h02);
    sel_50hz_i = 1'b1;
  endtask

  task automatic test_carry();
    do_reset();
    set_time(8'h91, 8'h59, 8'h59, 8'h09); ticks(1);
    check_time("R4 11PM wrap", 8'h00, 8'h00, 8'h00, 8'h00);
    do_reset();
    set_time(8'h11, 8'h59, 8'h59, 8'h09); ticks(1);
    check_time("R4 11AM wrap", 8'h80, 8'h00, 8'h00, 8'h00);
    do_reset();
    set_time(8'h09, 8'h59, 8'h59, 8'h09); ticks(1);
    check_time("R4 09 to 10", 8'h10, 8'h00, 8'h00, 8'h00);
    do_reset();
    set_time(8'h00, 8'h29, 8'h59, 8'h09); ticks(1);
    check_time("R3 seconds carry", 8'h00, 8'h30, 8'h00, 8'h00);
    do_reset();
    set_time(8'h00, 8'h00, 8'h09, 8'h09); ticks(1);
    check_time("R3 digit carry", 8'h00, 8'h00, 8'h10, 8'h00);
  endtask

  task automatic test_mask();
    do_reset();
    set_time(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    check_time("R5 mask", 8'h9F, 8'h7F, 8'h7F, 8'h0F);
  endtask

  task automatic test_alarm();
    logic al;
    logic [7:0] v;
    do_reset();
    chk("R7 no pulse from reset equality", {7'd0, alarm_o}, 8'd0);
    alarm_sel_i = 1'b1;
    wr(2'd3, 8'h60);               // masks to 00: alarm hours write must not halt (R10)
    wr(2'd0, 8'hF2);               // masks to 02 (R5)
    alarm_sel_i = 1'b0;
    check_time("R6 time untouched", 8'h00, 8'h00, 8'h00, 8'h00);
    tick(al); chk("R10 clock runs, no alarm yet", {7'd0, al}, 8'd0);
    rd(2'd0, v); chk("R10 tenths advanced", v, 8'h01);
    ticks(4);
    tick(al); chk("R7 alarm on match", {7'd0, al}, 8'd1);
    @(negedge clk_i);
    chk("R7 single cycle", {7'd0, alarm_o}, 8'd0);
    rd(2'd0, v); chk("R7 match tenths", v, 8'h02);
    // equalising write does not pulse
    alarm_sel_i = 1'b1;
    wr(2'd0, 8'h02);
    chk("R7 no pulse on write", {7'd0, alarm_o}, 8'd0);
    alarm_sel_i = 1'b0;
    set_time(8'h00, 8'h00, 8'h00, 8'h02);
    chk("R7 no pulse on time write", {7'd0, alarm_o}, 8'd0);
  endtask

  task automatic test_freeze();
    logic [7:0] v;
    do_reset();
    set_time(8'h00, 8'h00, 8'h59, 8'h09);
    rd(2'd3, v); chk("R8 hours at freeze", v, 8'h00);
    ticks(1);
    rd(2'd1, v); chk("R8 frozen seconds", v, 8'h59);
    rd(2'd2, v); chk("R8 frozen minutes", v, 8'h00);
    rd(2'd0, v); chk("R8 frozen tenths on release", v, 8'h09);
    rd(2'd2, v); chk("R8 live minutes", v, 8'h01);
    rd(2'd1, v); chk("R8 live seconds", v, 8'h00);
    rd(2'd0, v); chk("R8 live tenths", v, 8'h00);
  endtask

  task automatic test_halt();
    do_reset();
    wr(2'd3, 8'h03);
    ticks(3);
    check_time("R9 halted", 8'h03, 8'h00, 8'h00, 8'h00);
    wr(2'd0, 8'h04);
    ticks(1);
    check_time("R9 restarted", 8'h03, 8'h00, 8'h00, 8'h05);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_prescale(1'b1);
    test_prescale(1'b0);
    test_carry();
    test_mask();
    test_alarm();
    test_freeze();
    test_halt();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule